// File: doc/BRIEF.md
# Script Branch Condition Evaluator

This block decides whether a two-dword transfer-control instruction of a small bus-protocol script engine should take its branch. It receives the first instruction dword with a one-cycle `start` strobe. It decodes the opcode and the condition fields, and it forms a condition from any of three sources: the bus phase lines latched on the last request, the first byte received from the bus, and the ALU carry flag. A single polarity bit chooses branch-on-true or branch-on-false.

An instruction can ask to wait for a phase that has not been serviced yet. In that case the evaluator holds the instruction and raises `busy` until `phase_fresh_i` reports a new request, and only then compares. Results are registered. They appear with a one-cycle `done_o` and keep their value until the next evaluation completes. Next-address arithmetic, fetching and interrupt delivery belong to the surrounding sequencer.

Top module: `branch_cond_eval`

## Requirements
- R1: During and immediately after a synchronous active-low reset, `busy_o`, `done_o`, `cond_met_o` and `illegal_o` are 0 and `op_o` is 0.
- R2: Instruction bits 29:27 select the operation. Codes 000, 001, 010 and 011 appear on `op_o` as 0 (jump), 1 (call), 2 (return) and 3 (interrupt). Any code with bit 29 set appears as 4 (reserved), raises `illegal_o` and forces `cond_met_o` to 0.
- R3: An instruction whose bits 31:30 are not 10 raises `illegal_o` and forces `cond_met_o` to 0.
- R4: When the carry-test bit (bit 21) is set together with the data-compare enable (bit 18) or the phase-compare enable (bit 17), the instruction is illegal: `illegal_o` is 1 and `cond_met_o` is 0.
- R5: With carry test alone, `cond_met_o` equals `carry_i` when the polarity bit (bit 19) is 1, and equals its inverse when the polarity bit is 0.
- R6: The data compare matches when `first_byte_i` equals the value field (bits 7:0) at every bit position whose mask bit (bits 15:8) is 0. Bit positions whose mask bit is 1 are ignored.
- R7: In initiator mode (`target_mode_i` = 0), the phase compare matches when `bus_phase_i` equals bits 26:24, read as {message, control/data, in/out}.
- R8: In target mode, the phase-compare enable tests `atn_i` for 1 instead, and `bus_phase_i` has no effect.
- R9: When phase and data compares are both enabled, polarity 1 requires both to match, and polarity 0 requires both to mismatch.
- R10: With no compare enabled and no carry test, `cond_met_o` equals the polarity bit.
- R11: A legal, non-carry instruction with the wait bit (bit 16) set, started while `phase_fresh_i` is 0, sets `busy_o` from the next cycle. No `done_o` occurs while `phase_fresh_i` stays 0. In the first cycle where `phase_fresh_i` is 1, the compare uses that cycle's inputs, and `done_o` is 1 and `busy_o` is 0 one cycle later.
- R12: Otherwise a start gives `done_o` = 1 with valid results in the cycle after the start strobe, and `done_o` lasts one cycle.
- R13: A `start_i` while `busy_o` is 1 is ignored: the held instruction is the one evaluated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Evaluate `instr_i` this cycle |
| instr_i | input | 32 | First instruction dword |
| target_mode_i | input | 1 | 1 = target role, 0 = initiator role |
| bus_phase_i | input | 3 | Phase lines latched on the last request |
| phase_fresh_i | input | 1 | A not-yet-serviced phase has been latched |
| atn_i | input | 1 | Attention line, active high |
| first_byte_i | input | 8 | First byte received from the bus |
| carry_i | input | 1 | ALU carry flag |
| op_o | output | 3 | Decoded operation (0..3, 4 = reserved) |
| cond_met_o | output | 1 | Branch condition holds |
| illegal_o | output | 1 | Reserved opcode, wrong type or illegal field mix |
| busy_o | output | 1 | Waiting for a fresh phase |
| done_o | output | 1 | One-cycle pulse when results update |

## Verification
The bench builds the block with its default widths: an 8-bit received byte and a 3-bit phase. These widths let one directed case isolate the top bit under a 0x7F mask and let the message-in and message-out phase codes be compared exactly. Each case is built from explicit field values, so the polarity and both-mismatch rules, the target-mode attention test and the stall can be observed at the outputs. The stall case also issues a second start while waiting and confirms that the original instruction's opcode and condition are the ones reported.

// File: rtl/bce_pkg.sv
// Shared constants and types for the branch condition evaluator.
// Assumes a 32-bit first instruction dword with fixed field positions.
package bce_pkg;
    localparam int INSTR_W  = 32;
    localparam int BYTE_W   = 8;
    localparam int PHASE_W  = 3;

    localparam int TYPE_HI  = 31;
    localparam int TYPE_LO  = 30;
    localparam int OPC_HI   = 29;
    localparam int OPC_LO   = 27;
    localparam int PH_HI    = 26;
    localparam int PH_LO    = PH_HI - PHASE_W + 1;
    localparam int CARRY_B  = 21;
    localparam int POL_B    = 19;
    localparam int DCMP_B   = 18;
    localparam int PCMP_B   = 17;
    localparam int WAIT_B   = 16;
    localparam int VAL_LO   = 0;
    localparam int VAL_HI   = VAL_LO + BYTE_W - 1;
    localparam int MASK_LO  = VAL_HI + 1;
    localparam int MASK_HI  = MASK_LO + BYTE_W - 1;

    localparam logic [1:0] XFER_TYPE = 2'b10;

    typedef enum logic [2:0] {
        OP_JUMP   = 3'd0,
        OP_CALL   = 3'd1,
        OP_RETURN = 3'd2,
        OP_INTR   = 3'd3,
        OP_RSVD   = 3'd4
    } op_kind_e;

    typedef struct packed {
        op_kind_e               op;
        logic                   bad;
        logic                   carry_test;
        logic                   polarity;
        logic                   data_en;
        logic                   phase_en;
        logic                   wait_en;
        logic [PHASE_W-1:0]     phase_exp;
        logic [BYTE_W-1:0]      mask;
        logic [BYTE_W-1:0]      value;
    } ctl_fields_t;
endpackage

// File: rtl/bce_field_decode.sv
// Splits the first instruction dword into control fields and flags
// illegal encodings. Purely combinational; assumes bce_pkg layout.
module bce_field_decode
    import bce_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output ctl_fields_t        fields
);
    logic [2:0] opc;
    logic       rsvd_op;
    logic       wrong_type;
    logic       mix_bad;
    logic [2:0] unused_bits;

    assign unused_bits = {instr[23], instr[22], instr[20]};

    // Map the opcode field onto the operation kind.
    always_comb begin
        opc     = instr[OPC_HI:OPC_LO];
        rsvd_op = opc[2];
        case (opc)
            3'b000:  fields.op = OP_JUMP;
            3'b001:  fields.op = OP_CALL;
            3'b010:  fields.op = OP_RETURN;
            3'b011:  fields.op = OP_INTR;
            default: fields.op = OP_RSVD;
        endcase
    end

    // Extract the condition fields and classify illegal combinations.
    always_comb begin
        wrong_type        = (instr[TYPE_HI:TYPE_LO] != XFER_TYPE);
        mix_bad           = instr[CARRY_B] & (instr[DCMP_B] | instr[PCMP_B]);
        fields.bad        = wrong_type | rsvd_op | mix_bad;
        fields.carry_test = instr[CARRY_B];
        fields.polarity   = instr[POL_B];
        fields.data_en    = instr[DCMP_B];
        fields.phase_en   = instr[PCMP_B];
        fields.wait_en    = instr[WAIT_B];
        fields.phase_exp  = instr[PH_HI:PH_LO];
        fields.mask       = instr[MASK_HI:MASK_LO];
        fields.value      = instr[VAL_HI:VAL_LO];
    end
endmodule

// File: rtl/bce_cond_compare.sv
// Forms the branch condition from masked byte compare, phase or
// attention compare, and carry test under one polarity bit.
// Combinational; legality is handled by the caller.
module bce_cond_compare #(
    parameter int BYTE_W  = 8,
    parameter int PHASE_W = 3
) (
    input  logic               carry_test,
    input  logic               polarity,
    input  logic               data_en,
    input  logic               phase_en,
    input  logic [PHASE_W-1:0] phase_exp,
    input  logic [BYTE_W-1:0]  mask,
    input  logic [BYTE_W-1:0]  value,
    input  logic               target_mode,
    input  logic [PHASE_W-1:0] bus_phase,
    input  logic               atn,
    input  logic [BYTE_W-1:0]  first_byte,
    input  logic               carry,
    output logic               cond
);
    logic [BYTE_W-1:0] bit_ok;
    logic              data_hit;
    logic              phase_hit;

    // Per-bit compare; a set mask bit makes the position a don't-care.
    for (genvar i = 0; i < BYTE_W; i++) begin : g_bit
        assign bit_ok[i] = mask[i] | ~(first_byte[i] ^ value[i]);
    end

    assign data_hit = &bit_ok;

    // Initiator compares latched phase; target tests attention.
    assign phase_hit = target_mode ? atn : (bus_phase == phase_exp);

    // Combine enabled compares under the polarity bit.
    always_comb begin
        if (carry_test)
            cond = polarity ? carry : ~carry;
        else if (data_en && phase_en)
            cond = polarity ? (data_hit & phase_hit) : (~data_hit & ~phase_hit);
        else if (data_en)
            cond = polarity ? data_hit : ~data_hit;
        else if (phase_en)
            cond = polarity ? phase_hit : ~phase_hit;
        else
            cond = polarity;
    end
endmodule

// File: rtl/bce_seq.sv
// Sequencing for the evaluator: accepts a start, optionally holds the
// instruction until a fresh phase arrives, and registers the results.
// Assumes the decode and compare logic run on instr_act combinationally.
module bce_seq
    import bce_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [INSTR_W-1:0] instr_in,
    input  logic               phase_fresh,
    input  logic               need_wait,
    input  op_kind_e           op_in,
    input  logic               bad_in,
    input  logic               cond_in,
    output logic [INSTR_W-1:0] instr_act,
    output logic               busy,
    output logic               done,
    output op_kind_e           op_q,
    output logic               cond_q,
    output logic               illegal_q
);
    logic [INSTR_W-1:0] held;
    logic               accept;
    logic               park;
    logic               fire;

    // While waiting, evaluate the held copy instead of the live input.
    assign instr_act = busy ? held : instr_in;

    // Decide whether this cycle parks the instruction or completes it.
    always_comb begin
        accept = start & ~busy;
        park   = accept & need_wait & ~phase_fresh;
        fire   = (accept & ~park) | (busy & phase_fresh);
    end

    // Wait state, held instruction and registered results.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy      <= 1'b0;
            held      <= '0;
            done      <= 1'b0;
            op_q      <= OP_JUMP;
            cond_q    <= 1'b0;
            illegal_q <= 1'b0;
        end else begin
            done <= fire;
            if (park) begin
                busy <= 1'b1;
                held <= instr_in;
            end else if (busy && phase_fresh) begin
                busy <= 1'b0;
            end
            if (fire) begin
                op_q      <= op_in;
                illegal_q <= bad_in;
                cond_q    <= cond_in & ~bad_in;
            end
        end
    end

    a_r11_stall_holds: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !phase_fresh |=> busy && !done);

    a_r11_fresh_releases: assert property (@(posedge clk) disable iff (!rst_n)
        busy && phase_fresh |=> !busy && done);

    a_r12_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r13_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        busy && start && !phase_fresh |=> busy && $stable(held));
endmodule

// File: rtl/branch_cond_eval.sv
// Top of the branch condition evaluator for transfer-control
// instructions. Wires decode, compare and sequencing together.
// Assumes inputs are synchronous to clk; reset is synchronous, active low.
module branch_cond_eval
    import bce_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic [INSTR_W-1:0]  instr_i,
    input  logic                target_mode_i,
    input  logic [PHASE_W-1:0]  bus_phase_i,
    input  logic                phase_fresh_i,
    input  logic                atn_i,
    input  logic [BYTE_W-1:0]   first_byte_i,
    input  logic                carry_i,
    output logic [2:0]          op_o,
    output logic                cond_met_o,
    output logic                illegal_o,
    output logic                busy_o,
    output logic                done_o
);
    logic [INSTR_W-1:0] instr_act;
    ctl_fields_t        fld;
    logic               cond_raw;
    logic               need_wait;
    op_kind_e           op_q;

    bce_field_decode u_decode (
        .instr  (instr_act),
        .fields (fld)
    );

    bce_cond_compare #(
        .BYTE_W  (BYTE_W),
        .PHASE_W (PHASE_W)
    ) u_compare (
        .carry_test  (fld.carry_test),
        .polarity    (fld.polarity),
        .data_en     (fld.data_en),
        .phase_en    (fld.phase_en),
        .phase_exp   (fld.phase_exp),
        .mask        (fld.mask),
        .value       (fld.value),
        .target_mode (target_mode_i),
        .bus_phase   (bus_phase_i),
        .atn         (atn_i),
        .first_byte  (first_byte_i),
        .carry       (carry_i),
        .cond        (cond_raw)
    );

    // Stall only legal compare instructions that ask for a fresh phase.
    assign need_wait = fld.wait_en & ~fld.carry_test & ~fld.bad;

    bce_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start_i),
        .instr_in    (instr_i),
        .phase_fresh (phase_fresh_i),
        .need_wait   (need_wait),
        .op_in       (fld.op),
        .bad_in      (fld.bad),
        .cond_in     (cond_raw),
        .instr_act   (instr_act),
        .busy        (busy_o),
        .done        (done_o),
        .op_q        (op_q),
        .cond_q      (cond_met_o),
        .illegal_q   (illegal_o)
    );

    assign op_o = op_q;

    a_r4_illegal_no_branch: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !cond_met_o);

    a_r2_reserved_flagged: assert property (@(posedge clk) disable iff (!rst_n)
        done_o && (op_o == OP_RSVD) |-> illegal_o);
endmodule

// File: tb/test_branch_cond_eval.sv
module test_branch_cond_eval;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic        target_mode_i = 1'b0;
    logic [2:0]  bus_phase_i = '0;
    logic        phase_fresh_i = 1'b0;
    logic        atn_i = 1'b0;
    logic [7:0]  first_byte_i = '0;
    logic        carry_i = 1'b0;
    logic [2:0]  op_o;
    logic        cond_met_o, illegal_o, busy_o, done_o;

    int checks = 0;
    int errors = 0;

    branch_cond_eval i_branch_cond_eval (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i),
        .target_mode_i(target_mode_i), .bus_phase_i(bus_phase_i),
        .phase_fresh_i(phase_fresh_i), .atn_i(atn_i),
        .first_byte_i(first_byte_i), .carry_i(carry_i),
        .op_o(op_o), .cond_met_o(cond_met_o), .illegal_o(illegal_o),
        .busy_o(busy_o), .done_o(done_o)
    );

    always #4 clk = ~clk;

    function automatic logic [31:0] mk(input logic [2:0] opc, input logic [2:0] ph,
        input logic cy, input logic pol, input logic dc, input logic pc,
        input logic wt, input logic [7:0] mask, input logic [7:0] val);
        return {2'b10, opc, ph, 1'b0, 1'b0, cy, 1'b0, pol, dc, pc, wt, mask, val};
    endfunction

    task automatic chk(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    // Issue one instruction with immediate evaluation and sample results.
    task automatic issue(input logic [31:0] ins);
        @(negedge clk);
        instr_i = ins;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 busy", busy_o, 0);
        chk("R1 done", done_o, 0);
        chk("R1 cond", cond_met_o, 0);
        chk("R1 illegal", illegal_o, 0);
        chk("R1 op", op_o, 0);
    endtask

    task automatic t_opcodes;
        for (int k = 0; k < 4; k++) begin
            issue(mk(k[2:0], 3'd0, 0, 1, 0, 0, 0, 8'h00, 8'h00));
            chk("R2 op", op_o, k);
            chk("R2 legal", illegal_o, 0);
            chk("R12 done", done_o, 1);
        end
        @(negedge clk);
        chk("R12 done one cycle", done_o, 0);
        issue(mk(3'b101, 3'd0, 0, 1, 0, 0, 0, 8'h00, 8'h00));
        chk("R2 reserved op", op_o, 4);
        chk("R2 reserved illegal", illegal_o, 1);
        chk("R2 reserved cond", cond_met_o, 0);
    endtask

    task automatic t_type;
        logic [31:0] ins;
        ins = mk(3'd0, 3'd0, 0, 1, 0, 0, 0, 8'h00, 8'h00);
        ins[31:30] = 2'b01;
        issue(ins);
        chk("R3 illegal", illegal_o, 1);
        chk("R3 cond", cond_met_o, 0);
    endtask

    task automatic t_carry;
        carry_i = 1'b1;
        issue(mk(3'd0, 3'd0, 1, 1, 0, 0, 0, 8'h00, 8'h00));
        chk("R5 carry true", cond_met_o, 1);
        carry_i = 1'b0;
        issue(mk(3'd0, 3'd0, 1, 1, 0, 0, 0, 8'h00, 8'h00));
        chk("R5 no carry true", cond_met_o, 0);
        issue(mk(3'd0, 3'd0, 1, 0, 0, 0, 0, 8'h00, 8'h00));
        chk("R5 no carry false", cond_met_o, 1);
        carry_i = 1'b1;
        issue(mk(3'd1, 3'd0, 1, 1, 1, 0, 0, 8'hFF, 8'h00));
        chk("R4 carry+data illegal", illegal_o, 1);
        chk("R4 carry+data cond", cond_met_o, 0);
        issue(mk(3'd1, 3'd0, 1, 0, 0, 1, 0, 8'h00, 8'h00));
        chk("R4 carry+phase illegal", illegal_o, 1);
        carry_i = 1'b0;
    endtask

    task automatic t_data;
        first_byte_i = 8'h85;
        issue(mk(3'd0, 3'd0, 0, 1, 1, 0, 0, 8'h7F, 8'h80));
        chk("R6 msb set", cond_met_o, 1);
        first_byte_i = 8'h05;
        issue(mk(3'd0, 3'd0, 0, 1, 1, 0, 0, 8'h7F, 8'h80));
        chk("R6 msb clear", cond_met_o, 0);
        first_byte_i = 8'h3C;
        issue(mk(3'd0, 3'd0, 0, 1, 1, 0, 0, 8'h00, 8'h3C));
        chk("R6 exact", cond_met_o, 1);
        first_byte_i = 8'h3D;
        issue(mk(3'd0, 3'd0, 0, 1, 1, 0, 0, 8'h00, 8'h3C));
        chk("R6 exact miss", cond_met_o, 0);
    endtask

    task automatic t_phase;
        target_mode_i = 1'b0;
        bus_phase_i = 3'b111;
        issue(mk(3'd0, 3'b111, 0, 1, 0, 1, 0, 8'h00, 8'h00));
        chk("R7 phase hit", cond_met_o, 1);
        bus_phase_i = 3'b110;
        issue(mk(3'd0, 3'b111, 0, 1, 0, 1, 0, 8'h00, 8'h00));
        chk("R7 phase miss", cond_met_o, 0);
        target_mode_i = 1'b1;
        atn_i = 1'b1;
        issue(mk(3'd0, 3'b111, 0, 1, 0, 1, 0, 8'h00, 8'h00));
        chk("R8 atn active", cond_met_o, 1);
        atn_i = 1'b0;
        bus_phase_i = 3'b111;
        issue(mk(3'd0, 3'b111, 0, 1, 0, 1, 0, 8'h00, 8'h00));
        chk("R8 atn idle", cond_met_o, 0);
        target_mode_i = 1'b0;
    endtask

    task automatic t_both;
        bus_phase_i = 3'b010;
        first_byte_i = 8'h11;
        issue(mk(3'd0, 3'b010, 0, 1, 1, 1, 0, 8'h00, 8'h22));
        chk("R9 true one miss", cond_met_o, 0);
        issue(mk(3'd0, 3'b010, 0, 0, 1, 1, 0, 8'h00, 8'h22));
        chk("R9 false one miss", cond_met_o, 0);
        bus_phase_i = 3'b011;
        issue(mk(3'd0, 3'b010, 0, 0, 1, 1, 0, 8'h00, 8'h22));
        chk("R9 false both miss", cond_met_o, 1);
        bus_phase_i = 3'b010;
        first_byte_i = 8'h22;
        issue(mk(3'd0, 3'b010, 0, 1, 1, 1, 0, 8'h00, 8'h22));
        chk("R9 true both hit", cond_met_o, 1);
    endtask

    task automatic t_none;
        issue(mk(3'd0, 3'd0, 0, 1, 0, 0, 0, 8'h00, 8'h00));
        chk("R10 always", cond_met_o, 1);
        issue(mk(3'd0, 3'd0, 0, 0, 0, 0, 0, 8'h00, 8'h00));
        chk("R10 never", cond_met_o, 0);
    endtask

    task automatic t_wait;
        phase_fresh_i = 1'b0;
        bus_phase_i = 3'b000;
        issue(mk(3'd1, 3'b001, 0, 1, 0, 1, 1, 8'h00, 8'h00));
        chk("R11 busy", busy_o, 1);
        chk("R11 no done", done_o, 0);
        // Second start while waiting: an interrupt that would always branch.
        @(negedge clk);
        instr_i = mk(3'd3, 3'd0, 0, 1, 0, 0, 0, 8'h00, 8'h00);
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk("R13 still busy", busy_o, 1);
        chk("R13 no done", done_o, 0);
        repeat (3) @(negedge clk);
        chk("R11 still waiting", busy_o, 1);
        bus_phase_i = 3'b001;
        phase_fresh_i = 1'b1;
        @(negedge clk);
        phase_fresh_i = 1'b0;
        chk("R11 done", done_o, 1);
        chk("R11 released", busy_o, 0);
        chk("R11 cond at fresh", cond_met_o, 1);
        chk("R13 held op", op_o, 1);
        @(negedge clk);
        chk("R12 done drops", done_o, 0);
        phase_fresh_i = 1'b1;
        bus_phase_i = 3'b000;
        issue(mk(3'd2, 3'b001, 0, 1, 0, 1, 1, 8'h00, 8'h00));
        chk("R12 fresh already done", done_o, 1);
        chk("R12 fresh cond", cond_met_o, 0);
        phase_fresh_i = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_opcodes;
        t_type;
        t_carry;
        t_data;
        t_phase;
        t_both;
        t_none;
        t_wait;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(8 * 200000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule